// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line is given a trigger type when the block is built: level or edge. While hardware capture is on, each line latches into a status word. A status bit becomes pending when the matching bit of an enable word is also set. The block reports the number of the lowest pending line as a vector. It raises a single interrupt output when output gating is on and at least one line is pending.

Software reaches the block through a simple strobe bus of 32-bit words. The byte address is divided by four to pick one of eight words. The enable word can be changed in three ways: by a plain write, by a write that sets bits, or by a write that clears bits. A separate word takes acknowledge writes, which clear status bits.

A two-bit control word does two jobs. Bit 0 gates the output. Bit 1 turns on hardware capture. While capture is on, software cannot write the status word directly. All request inputs are expected to be synchronous to the block clock already.

Top module: `vec_intc`

## Requirements
- R1: After reset, every stored word is zero, `irq_out` is 0, and reading the vector word returns 0xFFFFFFFF.
- R2: A word is chosen by `bus_addr` divided by 4, and the low two address bits are ignored. The word numbers are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 control. Reading a word number of 8 or more returns zero. Writing one has no effect.
- R3: The pending word (word 1) always reads as status AND enable. Writes to it are ignored.
- R4: The vector word (word 6) reads as the index of the lowest set bit of pending, zero-extended. When pending is zero it reads 0xFFFFFFFF.
- R5: `irq_out` is 1 in the cycle after a clock edge at which control bit 0 is 1 and pending is nonzero. Otherwise it is 0.
- R6: A write to word 3 clears every status bit that is 1 in the written data.
- R7: A write to word 4 ORs the data into enable. A write to word 5 clears the enable bits that are 1 in the data. Reading words 3, 4 and 5 returns the last data written to each of them.
- R8: A write to the control word (word 7) keeps only data bits 1:0. The other bits read as zero.
- R9: A write to word 0 loads status only while control bit 1 is 0. While bit 1 is 1, the write is ignored.
- R10: A level-type line (edge-mask bit 0) sets its status bit at every clock edge where the line is 1 and control bit 1 is 1.
- R11: An edge-type line (edge-mask bit 1) sets its status bit only at a clock edge where the line is 1, it was 0 at the previous edge, and control bit 1 is 1. A line that stays high does not set the bit again after an acknowledge.
- R12: When hardware capture and an acknowledge write hit the same status bit at the same edge, the bit stays set.
- R13: `bus_rdata` is updated at the clock edge where `bus_rd` is 1. It shows the state from before any write at that same edge, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| src_in | input | NUM_SRC | Interrupt request lines, synchronous to `clk` |
| irq_out | output | 1 | Combined interrupt to the processor, registered |

## Verification
The bench builds the block with 32 lines, 32-bit words and an 8-bit byte address. The edge mask is 0x0000FF00, so lines 8 to 15 are edge-type and the rest are level-type. With this mask, one run can show a level line that stays latched through an acknowledge and an edge line that does not. The 8-bit address reaches word numbers above 7, which the out-of-range checks need. With 32 lines, the vector can be tested at its two extremes, index 0 and index 31.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

  localparam int REG_WORDS = 8;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_CTRL   = 3'd7
  } word_sel_e;

  localparam int CTRL_GATE_BIT = 0;
  localparam int CTRL_CAPT_BIT = 1;

endpackage

// File: rtl/vec_intc_capture.sv
module vec_intc_capture #(
  parameter int                 NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capt_en,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] set_vec
);

  logic [NUM_SRC-1:0] src_prev;
  logic [NUM_SRC-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) src_prev <= '0;
    else     src_prev <= src_in;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    if (EDGE_MASK[g]) begin : g_edge
      assign hit[g] = src_in[g] & ~src_prev[g];
    end else begin : g_level
      assign hit[g] = src_in[g];
    end
  end

  assign set_vec = capt_en ? hit : '0;

  // R11: an edge-type line never requests a set while it was already high
  a_r11_edge_once: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & EDGE_MASK & src_prev) == '0));

endmodule

// File: rtl/vec_intc_encoder.sv
module vec_intc_encoder #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic [DATA_W-1:0]  vector
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [IDX_W-1:0] idx;
  logic             found;

  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign vector = found ? DATA_W'(idx) : '1;

endmodule

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [DATA_W-1:0]  vector,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable,
  output logic [1:0]         ctrl,
  output logic [DATA_W-1:0]  bus_rdata
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]  word_idx;
  logic               in_range;
  word_sel_e          sel;
  logic [NUM_SRC-1:0] wsrc;
  logic [NUM_SRC-1:0] status_nx;
  logic [NUM_SRC-1:0] enable_nx;
  logic [DATA_W-1:0]  ack_last, seten_last, clren_last;
  logic [DATA_W-1:0]  rd_mux;
  logic               wr_hit;
  logic               unused_addr_lsb;

  assign word_idx        = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign in_range        = (word_idx <= WIDX_W'(REG_WORDS - 1));
  assign sel             = word_sel_e'(word_idx[SEL_W-1:0]);
  assign wsrc            = bus_wdata[NUM_SRC-1:0];
  assign wr_hit          = bus_wr && in_range;

  always_comb begin
    status_nx = status;
    if (wr_hit && sel == SEL_STATUS && !ctrl[CTRL_CAPT_BIT])
      status_nx = wsrc;
    if (wr_hit && sel == SEL_ACK)
      status_nx = status_nx & ~wsrc;
    status_nx = status_nx | set_vec;
  end

  always_comb begin
    enable_nx = enable;
    if (wr_hit) begin
      unique case (sel)
        SEL_ENABLE: enable_nx = wsrc;
        SEL_SETEN:  enable_nx = enable | wsrc;
        SEL_CLREN:  enable_nx = enable & ~wsrc;
        default:    enable_nx = enable;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status     <= '0;
      enable     <= '0;
      ctrl       <= '0;
      ack_last   <= '0;
      seten_last <= '0;
      clren_last <= '0;
    end else begin
      status <= status_nx;
      enable <= enable_nx;
      if (wr_hit) begin
        case (sel)
          SEL_CTRL:  ctrl       <= bus_wdata[1:0];
          SEL_ACK:   ack_last   <= bus_wdata;
          SEL_SETEN: seten_last <= bus_wdata;
          SEL_CLREN: clren_last <= bus_wdata;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      unique case (sel)
        SEL_STATUS: rd_mux = DATA_W'(status);
        SEL_PEND:   rd_mux = DATA_W'(pending);
        SEL_ENABLE: rd_mux = DATA_W'(enable);
        SEL_ACK:    rd_mux = ack_last;
        SEL_SETEN:  rd_mux = seten_last;
        SEL_CLREN:  rd_mux = clren_last;
        SEL_VECTOR: rd_mux = vector;
        SEL_CTRL:   rd_mux = DATA_W'(ctrl);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R9: with capture on, a status write adds no bit that capture did not request
  a_r9_status_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && sel == SEL_STATUS && ctrl[CTRL_CAPT_BIT])
    |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

  // R6: acknowledged bits are clear afterwards unless capture re-set them
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && sel == SEL_ACK)
    |=> ((status & $past(wsrc) & ~$past(set_vec)) == '0));

  // R12: a capture request always lands in status
  a_r12_capture_wins: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R7: set-enable writes leave every written bit enabled
  a_r7_seten_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && sel == SEL_SETEN) |=> ((enable & $past(wsrc)) == $past(wsrc)));

  // R2: writes outside the word range change no stored word
  a_r2_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !in_range && set_vec == '0)
    |=> ($stable(status) && $stable(enable) && $stable(ctrl)));

endmodule

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int                 NUM_SRC   = 32,
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 8,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out
);

  import vec_intc_pkg::*;

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] set_vec, status, enable, pending;
  logic [1:0]         ctrl;
  logic [DATA_W-1:0]  vector;

  vec_intc_capture #(
    .NUM_SRC   (NUM_SRC),
    .EDGE_MASK (EDGE_MASK)
  ) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capt_en (ctrl[CTRL_CAPT_BIT]),
    .src_in  (src_in),
    .set_vec (set_vec)
  );

  vec_intc_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .set_vec   (set_vec),
    .pending   (pending),
    .vector    (vector),
    .status    (status),
    .enable    (enable),
    .ctrl      (ctrl),
    .bus_rdata (bus_rdata)
  );

  assign pending = status & enable;

  vec_intc_encoder #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_encoder (
    .pending (pending),
    .vector  (vector)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= ctrl[CTRL_GATE_BIT] && (pending != '0);
  end

  // R4: empty pending gives all-ones vector
  a_r4_vec_empty: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |-> (vector == '1));

  // R4: vector names a pending line with no lower pending line
  a_r4_vec_lowest: assert property (@(posedge clk) disable iff (rst)
    (pending != '0) |-> (pending[vector[IDX_W-1:0]] &&
      ((pending & ((NUM_SRC'(1) << vector[IDX_W-1:0]) - NUM_SRC'(1))) == '0)));

  // R5: output only follows a gated, nonempty pending state
  a_r5_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(ctrl[CTRL_GATE_BIT]) && ($past(pending) != '0)));

endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;

  localparam int                NSRC = 32;
  localparam int                DW   = 32;
  localparam int                AW   = 8;
  localparam logic [NSRC-1:0]   EMSK = 32'h0000_FF00;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic [NSRC-1:0] src_in = '0;
  logic            irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct { logic [DW-1:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  logic rd_seen = 1'b0;

  always #4 clk = ~clk;

  vec_intc #(.NUM_SRC(NSRC), .DATA_W(DW), .ADDR_W(AW), .EDGE_MASK(EMSK)) u_vec_intc (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare each read result against the queued expectation
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (bus_rdata !== e.exp) begin
        bad++;
        $display("FAIL %s actual=%08h expected=%08h", e.tag, bus_rdata, e.exp);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    total++;
    if (irq_out !== e) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq_out, e);
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(8'h00, 32'h0, "R1 status");
    rd(8'h04, 32'h0, "R1 pending");
    rd(8'h08, 32'h0, "R1 enable");
    rd(8'h1C, 32'h0, "R1 ctrl");
    rd(8'h18, 32'hFFFF_FFFF, "R1 vector");
    // R9 direct status write while capture off
    wr(8'h00, 32'h0000_0030);
    rd(8'h00, 32'h0000_0030, "R9 status load");
    rd(8'h04, 32'h0, "R3 pending masked");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0, "R3 pending write ignored");
    // R7 set-enable
    wr(8'h10, 32'h0000_0020);
    rd(8'h08, 32'h0000_0020, "R7 enable after set");
    rd(8'h04, 32'h0000_0020, "R3 pending");
    rd(8'h18, 32'h5, "R4 vector 5");
    wr(8'h10, 32'h0000_0010);
    rd(8'h08, 32'h0000_0030, "R7 enable or");
    rd(8'h18, 32'h4, "R4 vector 4");
    rd(8'h10, 32'h0000_0010, "R7 set-enable readback");
    chk_irq(1'b0, "R5 gate off");
    // R8 control keeps two bits
    wr(8'h1C, 32'hFFFF_FFFD);
    rd(8'h1C, 32'h1, "R8 ctrl");
    chk_irq(1'b1, "R5 irq on");
    // R6 acknowledge
    wr(8'h0C, 32'h0000_0010);
    rd(8'h00, 32'h0000_0020, "R6 ack");
    rd(8'h18, 32'h5, "R4 vector after ack");
    rd(8'h0C, 32'h0000_0010, "R7 ack readback");
    wr(8'h14, 32'h0000_0020);
    rd(8'h08, 32'h0000_0010, "R7 clear-enable");
    rd(8'h14, 32'h0000_0020, "R7 clear-enable readback");
    rd(8'h18, 32'hFFFF_FFFF, "R4 vector empty");
    chk_irq(1'b0, "R5 irq off no pending");
    // R2 range and byte address
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R2 out of range read");
    rd(8'h00, 32'h0000_0020, "R2 status untouched");
    rd(8'h09, 32'h0000_0010, "R2 low bits ignored");
    // R13 read shows state before same-edge write
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'h3;
    begin exp_t it; it.exp = 32'h1; it.tag = "R13 read before write"; sb_q.push_back(it); end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    rd(8'h1C, 32'h3, "R13 ctrl after write");
    // R9 status locked while capturing
    wr(8'h00, 32'h0000_00FF);
    rd(8'h00, 32'h0000_0020, "R9 locked");
    // R10 level capture, R12 capture beats ack
    src_in[3] = 1'b1;
    idle(2);
    rd(8'h00, 32'h0000_0028, "R10 level set");
    wr(8'h0C, 32'h0000_0008);
    rd(8'h00, 32'h0000_0028, "R12 capture wins");
    src_in[3] = 1'b0;
    wr(8'h0C, 32'h0000_0008);
    rd(8'h00, 32'h0000_0020, "R10 level cleared");
    // R11 edge capture
    src_in[9] = 1'b1;
    idle(2);
    rd(8'h00, 32'h0000_0220, "R11 edge set");
    wr(8'h0C, 32'h0000_0200);
    idle(2);
    rd(8'h00, 32'h0000_0020, "R11 no re-set while high");
    src_in[9] = 1'b0;
    idle(1);
    src_in[9] = 1'b1;
    idle(2);
    rd(8'h00, 32'h0000_0220, "R11 new edge");
    wr(8'h1C, 32'h1);
    src_in[10] = 1'b1;
    idle(2);
    rd(8'h00, 32'h0000_0220, "R11 capture off");
    wr(8'h1C, 32'h3);
    idle(2);
    rd(8'h00, 32'h0000_0220, "R11 no edge on enable");
    // R5 with pending and gating
    wr(8'h10, 32'h0000_0200);
    rd(8'h18, 32'h9, "R4 vector 9");
    chk_irq(1'b1, "R5 irq pending");
    wr(8'h1C, 32'h2);
    chk_irq(1'b0, "R5 gate cleared");
    // R4 extremes
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0, "R6 ack all");
    wr(8'h1C, 32'h0);
    wr(8'h00, 32'h8000_0001);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R4 vector 0");
    wr(8'h0C, 32'h0000_0001);
    rd(8'h18, 32'h1F, "R4 vector 31");
    idle(3);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule